// File: doc/BRIEF.md
# Bus Address Decoder with Flash Wait Request

This block is pure combinational decode for a 16-bit word-organised processor bus with one slow Flash part and one fast RAM part. It examines the live address and four window hit flags. From them it produces an active-low RAM select, an active-low Flash select and a READY line. READY drops for every Flash access so that the processor inserts one wait state.

The direct mapping sends two low address ranges to the same word locations in Flash and the top range to RAM. The bottom range is the processor's internal register space and selects nothing. The range just below 2000h holds the block-window and device addresses, so it is not direct memory. The window hit flags come from a neighbouring decoder that owns those special addresses. A Flash window data access selects Flash and asks for a wait. A RAM window data access selects RAM and runs at full speed.

READY is decoded from the address alone, with no address-latch-enable qualification. It therefore settles as soon as the address is on the bus, ahead of the processor's early READY sampling point. Neither the decoder nor the selects hold any state.

Top module: `mem_sel_decode`

## Requirements
- R1: With no window flag set, addresses 0000h to 01FFh leave both selects high (deasserted) and READY high.
- R2: With no window flag set, addresses 0200h to 1EFFh drive the Flash select low, the RAM select high and READY low.
- R3: With no window flag set, addresses 2000h to 8FFFh drive the Flash select low, the RAM select high and READY low.
- R4: With no window flag set, addresses 9000h to FFFFh drive the RAM select low, the Flash select high and READY high.
- R5: With no window flag set, addresses 1F00h to 1FFFh leave both selects high and READY high.
- R6: When either Flash window flag (read or write) is set, the Flash select is low, the RAM select is high and READY is low, whatever the address.
- R7: When a RAM window flag (read or write) is set and no Flash window flag is set, the RAM select is low, the Flash select is high and READY is high, whatever the address.
- R8: When a Flash window flag and a RAM window flag are set together, the Flash window wins and the result is the one given in R6.
- R9: The two selects are never low together, and READY is low exactly when the Flash select is low. Outputs follow the inputs with no clock and no latch enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busAddr | input | 16 | Live word address from the processor bus |
| flashRdHit | input | 1 | Address is the Flash block-read window data address |
| flashWrHit | input | 1 | Address is the Flash block-write window data address |
| ramRdHit | input | 1 | Address is the RAM block-read window data address |
| ramWrHit | input | 1 | Address is the RAM block-write window data address |
| ramSelN | output | 1 | Active-low RAM chip select |
| flashSelN | output | 1 | Active-low Flash chip select |
| readyOut | output | 1 | Low requests one wait state (Flash access) |

## Verification
A window hit flag can be raised while the address also falls in a direct range. The worst case is a Flash window hit on an address in the RAM range, or a RAM window hit inside a Flash range, where the direct decode and the window override compete in the same cycle. The bench first sweeps every address with all flags clear. It then applies all sixteen flag combinations on a strided subset of addresses and on every range boundary. Each result is judged against an expectation worked out from the address arithmetic, with the window override, and the Flash-first priority between windows, applied ahead of the direct decode.

// File: rtl/mem_sel_decode_pkg.sv
package mem_sel_decode_pkg;

  // Window strobes handed from the arbitration control to the range datapath
  typedef struct packed {
    logic winFlash;  // a Flash window data address is on the bus
    logic winRam;    // a RAM window data address is on the bus (Flash window absent)
    logic winAny;    // some window owns this cycle; direct decode is suppressed
  } winStrobes_t;

endpackage

// File: rtl/mem_win_arbiter.sv
module mem_win_arbiter
  import mem_sel_decode_pkg::*;
(
  input  logic        flashRdHit,
  input  logic        flashWrHit,
  input  logic        ramRdHit,
  input  logic        ramWrHit,
  output winStrobes_t strobes
);

  logic flashReq;
  logic ramReq;

  always_comb begin
    flashReq         = flashRdHit | flashWrHit;
    ramReq           = ramRdHit | ramWrHit;
    // Flash window has priority over the RAM window
    strobes.winFlash = flashReq;
    strobes.winRam   = ramReq & ~flashReq;
    strobes.winAny   = flashReq | ramReq;
  end

endmodule

// File: rtl/mem_range_sel.sv
module mem_range_sel
  import mem_sel_decode_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int FLASH_RANGES = 2,
  parameter logic [FLASH_RANGES*ADDR_W-1:0] FLASH_LO = {16'h2000, 16'h0200},
  parameter logic [FLASH_RANGES*ADDR_W-1:0] FLASH_HI = {16'h8FFF, 16'h1EFF},
  parameter logic [ADDR_W-1:0] RAM_LO = 16'h9000,
  parameter logic [ADDR_W-1:0] RAM_HI = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  winStrobes_t       strobes,
  output logic              ramSelN,
  output logic              flashSelN,
  output logic              readyOut
);

  logic [FLASH_RANGES-1:0] flashHitVec;
  logic directFlash;
  logic directRam;
  logic flashSel;
  logic ramSel;

  for (genvar g = 0; g < FLASH_RANGES; g++) begin : g_flashRange
    localparam logic [ADDR_W-1:0] LO = FLASH_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = FLASH_HI[g*ADDR_W +: ADDR_W];
    assign flashHitVec[g] = (busAddr >= LO) && (busAddr <= HI);
  end

  always_comb begin
    directFlash = |flashHitVec;
    directRam   = (busAddr >= RAM_LO) && (busAddr <= RAM_HI);
    flashSel    = strobes.winFlash | (~strobes.winAny & directFlash);
    ramSel      = strobes.winRam   | (~strobes.winAny & directRam);
    flashSelN   = ~flashSel;
    ramSelN     = ~ramSel;
    // Wait request follows the Flash select, never an address latch strobe
    readyOut    = ~flashSel;
  end

endmodule

// File: rtl/mem_sel_decode.sv
module mem_sel_decode
  import mem_sel_decode_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int FLASH_RANGES = 2,
  parameter logic [FLASH_RANGES*ADDR_W-1:0] FLASH_LO = {16'h2000, 16'h0200},
  parameter logic [FLASH_RANGES*ADDR_W-1:0] FLASH_HI = {16'h8FFF, 16'h1EFF},
  parameter logic [ADDR_W-1:0] RAM_LO = 16'h9000,
  parameter logic [ADDR_W-1:0] RAM_HI = 16'hFFFF
) (
  input  logic [15:0] busAddr,
  input  logic        flashRdHit,
  input  logic        flashWrHit,
  input  logic        ramRdHit,
  input  logic        ramWrHit,
  output logic        ramSelN,
  output logic        flashSelN,
  output logic        readyOut
);

  winStrobes_t strobes;

  mem_win_arbiter u_arb (
    .flashRdHit (flashRdHit),
    .flashWrHit (flashWrHit),
    .ramRdHit   (ramRdHit),
    .ramWrHit   (ramWrHit),
    .strobes    (strobes)
  );

  mem_range_sel #(
    .ADDR_W       (ADDR_W),
    .FLASH_RANGES (FLASH_RANGES),
    .FLASH_LO     (FLASH_LO),
    .FLASH_HI     (FLASH_HI),
    .RAM_LO       (RAM_LO),
    .RAM_HI       (RAM_HI)
  ) u_sel (
    .busAddr   (busAddr[ADDR_W-1:0]),
    .strobes   (strobes),
    .ramSelN   (ramSelN),
    .flashSelN (flashSelN),
    .readyOut  (readyOut)
  );

endmodule

// File: rtl/mem_sel_decode_chk.sv
module mem_sel_decode_chk (
  input logic [15:0] busAddr,
  input logic        flashRdHit,
  input logic        flashWrHit,
  input logic        ramRdHit,
  input logic        ramWrHit,
  input logic        ramSelN,
  input logic        flashSelN,
  input logic        readyOut
);

  always_comb begin
    // R9
    sel_exclusive_chk: assert (ramSelN | flashSelN);
    // R9
    ready_follows_flash_chk: assert (readyOut == flashSelN);
    // R6
    flash_window_chk: assert (!(flashRdHit | flashWrHit) || (!flashSelN && ramSelN));
    // R7
    ram_window_chk: assert (!((ramRdHit | ramWrHit) && !(flashRdHit | flashWrHit)) || (!ramSelN && flashSelN));
    // R1
    reg_space_quiet_chk: assert (!((busAddr < 16'h0200) && !(flashRdHit | flashWrHit | ramRdHit | ramWrHit)) || (ramSelN && flashSelN && readyOut));
    // R4
    ram_range_chk: assert (!((busAddr >= 16'h9000) && !(flashRdHit | flashWrHit | ramRdHit | ramWrHit)) || (!ramSelN && readyOut));
  end

endmodule

bind mem_sel_decode mem_sel_decode_chk chk_i (
  .busAddr    (busAddr),
  .flashRdHit (flashRdHit),
  .flashWrHit (flashWrHit),
  .ramRdHit   (ramRdHit),
  .ramWrHit   (ramWrHit),
  .ramSelN    (ramSelN),
  .flashSelN  (flashSelN),
  .readyOut   (readyOut)
);

// File: tb/mem_sel_decode_tb_top.sv
module mem_sel_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] busAddr = 16'h0000;
  logic        flashRdHit = 1'b0;
  logic        flashWrHit = 1'b0;
  logic        ramRdHit = 1'b0;
  logic        ramWrHit = 1'b0;
  logic        ramSelN;
  logic        flashSelN;
  logic        readyOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mem_sel_decode dut_i (
    .busAddr    (busAddr),
    .flashRdHit (flashRdHit),
    .flashWrHit (flashWrHit),
    .ramRdHit   (ramRdHit),
    .ramWrHit   (ramWrHit),
    .ramSelN    (ramSelN),
    .flashSelN  (flashSelN),
    .readyOut   (readyOut)
  );

  task automatic apply(input logic [15:0] a, input logic [3:0] f);
    @(posedge clk);
    busAddr    <= a;
    flashRdHit <= f[0];
    flashWrHit <= f[1];
    ramRdHit   <= f[2];
    ramWrHit   <= f[3];
    @(negedge clk);
  endtask

  task automatic judge(input logic [15:0] a, input logic [3:0] f);
    bit fw = f[0] | f[1];
    bit rw = f[2] | f[3];
    bit expFlash;
    bit expRam;
    string req;
    if (fw && rw) begin expFlash = 1; expRam = 0; req = "R8"; end
    else if (fw)  begin expFlash = 1; expRam = 0; req = "R6"; end
    else if (rw)  begin expFlash = 0; expRam = 1; req = "R7"; end
    else if (a <= 16'h01FF) begin expFlash = 0; expRam = 0; req = "R1"; end
    else if (a <= 16'h1EFF) begin expFlash = 1; expRam = 0; req = "R2"; end
    else if (a <= 16'h1FFF) begin expFlash = 0; expRam = 0; req = "R5"; end
    else if (a <= 16'h8FFF) begin expFlash = 1; expRam = 0; req = "R3"; end
    else begin expFlash = 0; expRam = 1; req = "R4"; end
    checks++;
    if ({flashSelN, ramSelN, readyOut} !== {~expFlash, ~expRam, ~expFlash}) begin
      errors++;
      $display("FAIL %s addr=%h flags=%b actual flashSelN/ramSelN/ready=%b%b%b expected=%b%b%b",
               req, a, f, flashSelN, ramSelN, readyOut, ~expFlash, ~expRam, ~expFlash);
    end
    // R9: structural relations between the outputs
    checks++;
    if (!(ramSelN | flashSelN) || (readyOut !== flashSelN)) begin
      errors++;
      $display("FAIL R9 addr=%h flags=%b actual flashSelN/ramSelN/ready=%b%b%b expected=exclusive,ready==flashSelN",
               a, f, flashSelN, ramSelN, readyOut);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [15:0] corners [10] = '{16'h0000, 16'h01FF, 16'h0200, 16'h1EFF, 16'h1F00,
                                  16'h1FFF, 16'h2000, 16'h8FFF, 16'h9000, 16'hFFFF};
    repeat (3) @(posedge clk);
    // reset state: address zero, no flags (R1)
    @(negedge clk);
    judge(16'h0000, 4'b0000);
    rst <= 1'b0;
    // R1..R5: full address sweep with no window flags
    for (int a = 0; a < 65536; a++) begin
      apply(a[15:0], 4'b0000);
      judge(a[15:0], 4'b0000);
    end
    // R6, R7, R8: every flag combination on strided addresses
    for (int a = 0; a < 65536; a += 64) begin
      for (int f = 0; f < 16; f++) begin
        apply(a[15:0], f[3:0]);
        judge(a[15:0], f[3:0]);
      end
    end
    // boundaries with every flag combination
    for (int c = 0; c < 10; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(corners[c], f[3:0]);
        judge(corners[c], f[3:0]);
      end
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule